// File: doc/BRIEF.md
# DRAM Self-Refresh Power Sequencer

This block takes over from firmware the job of parking an external DRAM in self-refresh and waking it up again. It is a bus master on a simple register port with request and acknowledge. A target-select bit on that port picks one of two register spaces: the memory controller (select 0) or its PHY (select 1). Each step of its fixed script is one of three kinds. A read-modify-write changes only the masked bits of a register. A full write stores a value. A poll re-reads a status register until a masked field matches an expected code.

An enter command runs the sleep script. It quiesces the host ports, asks the controller for software self-refresh, optionally bypasses the PHY DLL, and powers down PHY I/O. An exit command runs the wake script. It restores PHY power, re-initialises the PHY inside two quasi-dynamic programming windows, leaves self-refresh and re-opens the ports. The block reports `busy` and a one-cycle `done`, tracks whether the memory is in self-refresh, and raises a sticky error if a poll never matches.

States: IDLE (wait for a command), ISSUE (decode the current step, or skip it), READ (read request, RMW capture or poll compare), WRITE (write request), ADVANCE (next step or finish), ERROR (poll timed out, held until reset). Transitions: IDLE→ISSUE on an accepted command. ISSUE→ADVANCE on a skipped step, ISSUE→WRITE for a full write, and ISSUE→READ otherwise. READ→WRITE after an RMW read. READ→ADVANCE on a poll match. READ→ERROR when the poll budget is spent. WRITE→ADVANCE on acknowledge. ADVANCE→IDLE after the last step, and ADVANCE→ISSUE otherwise.

Top module: `sr_seq`

## Requirements
- R1: On enter, bit 0 of the five port control registers (controller 0x40, 0x44, 0x48, 0x4C, 0x50) is cleared in that order. Each change is a read followed by a write. The port status register (0x3C) is then polled until bits 4:0 read zero.
- R2: Next, bit 5 of the power control register (0x30) is set by read-modify-write. The controller status register (0x04) is then polled until bits 5:4 equal 2.
- R3: When `backup_mode` is 0 at the command, bit 17 of the PHY init register (PHY 0x04) is set next. When it is 1, that write is left out.
- R4: Entry ends by setting three PHY power-down masks in this order: receivers (0x28, 0x8), address/command/clock/select (0x24, 0x50008), termination (0x2C, 0x10000). Then `done` pulses for one cycle and `in_self_refresh` becomes 1.
- R5: Exit first clears those three masks in the same order, and then clears bit 17 of the PHY init register.
- R6: A first programming window follows. It writes 0 to the software control register (0x20) and clears bit 0 of the misc register (0x28). It then writes 1 to 0x20 and polls software status (0x24) until bit 0 is set.
- R7: The PHY init register is then written as a whole with 0x17, with no read before it. PHY general status (0x0C) is then polled until bit 0 is set.
- R8: A second window writes 0x20←0, sets bit 0 of 0x28, writes 0x20←1 and polls 0x24 bit 0. After it, bit 5 of 0x30 is cleared. Status 0x04 is then polled until bits 2:0 equal 1. Bit 0 is then set in the five port registers in order. Finally `done` pulses and `in_self_refresh` becomes 0.
- R9: A poll re-reads until its field matches. If the read numbered `poll_limit` (a value of 0 counts as 1) still mismatches, the block enters ERROR: `err` is 1, `busy` is 0, the bus stays quiet, commands are ignored, and only reset leaves it.
- R10: Commands that arrive while `busy` is 1 are ignored. Enter has priority when both are asserted. An enter while in self-refresh, or an exit while not in self-refresh, pulses `done` in the cycle after the command and makes no bus access.
- R11: `bus_req` is held with stable `bus_we`, `bus_sel`, `bus_addr` and `bus_wdata` until the cycle in which `bus_ack` is seen.
- R12: After reset the block is idle: `busy`, `done`, `err`, `in_self_refresh` and `bus_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enter_req | input | 1 | Start the self-refresh entry script |
| exit_req | input | 1 | Start the self-refresh exit script |
| backup_mode | input | 1 | Requested low-power mode is backup (skips DLL bypass) |
| poll_limit | input | 16 | Maximum reads per poll before error |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_sel | output | 1 | Target: 0 controller, 1 PHY |
| bus_addr | output | 8 | Register byte offset |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access complete; read data valid |
| bus_rdata | input | 32 | Read data |
| busy | output | 1 | Script in progress |
| done | output | 1 | One-cycle completion pulse |
| in_self_refresh | output | 1 | Memory currently in self-refresh |
| err | output | 1 | Poll timeout, sticky until reset |

## Verification
The assertions assume a well-behaved target. It raises `bus_ack` only while `bus_req` is high and only for one cycle, it returns read data together with that acknowledge, and `poll_limit` does not change while a script runs. The bench's register model acknowledges every access exactly once, one cycle after the request, and never acknowledges unprompted. It changes `poll_limit` only while the block is idle, and it scripts status values only as functions of registers the block itself wrote, plus a read counter for the port status register.

// File: rtl/sr_seq_pkg.sv
package sr_seq_pkg;
    parameter int SRS_ADDR_W = 8;
    parameter int SRS_DATA_W = 32;

    typedef enum logic [1:0] {
        OP_RMW   = 2'd0,
        OP_WRITE = 2'd1,
        OP_POLL  = 2'd2
    } op_e;

    typedef struct packed {
        op_e                    op;
        logic                   sel;
        logic [SRS_ADDR_W-1:0]  addr;
        logic [SRS_DATA_W-1:0]  mask;
        logic [SRS_DATA_W-1:0]  value;
        logic                   backup_skip;
    } step_t;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ISSUE   = 3'd1,
        ST_READ    = 3'd2,
        ST_WRITE   = 3'd3,
        ST_ADVANCE = 3'd4,
        ST_ERROR   = 3'd5
    } state_e;
endpackage

// File: rtl/sr_seq_script.sv
module sr_seq_script
    import sr_seq_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int IDX_W     = 5,
    parameter logic [SRS_ADDR_W-1:0] C_PORT_CTL  = 8'h40,
    parameter int                    PORT_STRIDE = 4,
    parameter logic [SRS_ADDR_W-1:0] C_PORT_STAT = 8'h3C,
    parameter logic [SRS_ADDR_W-1:0] C_PWR_CTL   = 8'h30,
    parameter logic [SRS_ADDR_W-1:0] C_STATUS    = 8'h04,
    parameter logic [SRS_ADDR_W-1:0] C_SW_CTL    = 8'h20,
    parameter logic [SRS_ADDR_W-1:0] C_SW_STAT   = 8'h24,
    parameter logic [SRS_ADDR_W-1:0] C_MISC      = 8'h28,
    parameter logic [SRS_ADDR_W-1:0] P_INIT      = 8'h04,
    parameter logic [SRS_ADDR_W-1:0] P_GSTAT     = 8'h0C,
    parameter logic [SRS_ADDR_W-1:0] P_RX_CTL    = 8'h28,
    parameter logic [SRS_ADDR_W-1:0] P_IO_CTL    = 8'h24,
    parameter logic [SRS_ADDR_W-1:0] P_TERM_CTL  = 8'h2C,
    parameter logic [SRS_DATA_W-1:0] M_PORT_EN   = 32'h1,
    parameter logic [SRS_DATA_W-1:0] M_PORT_BUSY = 32'h1F,
    parameter logic [SRS_DATA_W-1:0] M_SR_REQ    = 32'h20,
    parameter logic [SRS_DATA_W-1:0] M_SR_TYPE   = 32'h30,
    parameter logic [SRS_DATA_W-1:0] V_SR_SW     = 32'h20,
    parameter logic [SRS_DATA_W-1:0] M_OPMODE    = 32'h7,
    parameter logic [SRS_DATA_W-1:0] V_OP_NORMAL = 32'h1,
    parameter logic [SRS_DATA_W-1:0] M_INIT_EN   = 32'h1,
    parameter logic [SRS_DATA_W-1:0] V_SW_DONE   = 32'h1,
    parameter logic [SRS_DATA_W-1:0] M_SW_ACK    = 32'h1,
    parameter logic [SRS_DATA_W-1:0] V_PHY_INIT  = 32'h17,
    parameter logic [SRS_DATA_W-1:0] M_INIT_DONE = 32'h1,
    parameter logic [SRS_DATA_W-1:0] M_DLL_BYP   = 32'h2_0000,
    parameter logic [SRS_DATA_W-1:0] M_RX_PD     = 32'h8,
    parameter logic [SRS_DATA_W-1:0] M_IO_PD     = 32'h5_0008,
    parameter logic [SRS_DATA_W-1:0] M_TERM_PD   = 32'h1_0000
) (
    input  logic             exit_dir,
    input  logic [IDX_W-1:0] idx,
    output step_t            step,
    output logic             last
);
    localparam int ENTRY_LEN = NUM_PORTS + 7;
    localparam int EXIT_LEN  = NUM_PORTS + 16;
    localparam int EXIT_PORT0 = 16;

    function automatic step_t mk(op_e op, logic sel, logic [SRS_ADDR_W-1:0] addr,
                                 logic [SRS_DATA_W-1:0] mask,
                                 logic [SRS_DATA_W-1:0] value, logic skip);
        step_t s;
        s.op = op;
        s.sel = sel;
        s.addr = addr;
        s.mask = mask;
        s.value = value;
        s.backup_skip = skip;
        return s;
    endfunction

    function automatic logic [SRS_ADDR_W-1:0] port_ofs(int k);
        return C_PORT_CTL + SRS_ADDR_W'(k * PORT_STRIDE);
    endfunction

    int pos;

    always_comb begin
        step = mk(OP_POLL, 1'b0, '0, '0, '0, 1'b0);
        pos  = int'(idx);
        if (!exit_dir) begin
            last = (pos == ENTRY_LEN - 1);
            if (pos < NUM_PORTS) begin
                step = mk(OP_RMW, 1'b0, port_ofs(pos), M_PORT_EN, '0, 1'b0);
            end else begin
                unique case (pos - NUM_PORTS)
                    0: step = mk(OP_POLL, 1'b0, C_PORT_STAT, M_PORT_BUSY, '0, 1'b0);
                    1: step = mk(OP_RMW,  1'b0, C_PWR_CTL, M_SR_REQ, M_SR_REQ, 1'b0);
                    2: step = mk(OP_POLL, 1'b0, C_STATUS, M_SR_TYPE, V_SR_SW, 1'b0);
                    3: step = mk(OP_RMW,  1'b1, P_INIT, M_DLL_BYP, M_DLL_BYP, 1'b1);
                    4: step = mk(OP_RMW,  1'b1, P_RX_CTL, M_RX_PD, M_RX_PD, 1'b0);
                    5: step = mk(OP_RMW,  1'b1, P_IO_CTL, M_IO_PD, M_IO_PD, 1'b0);
                    6: step = mk(OP_RMW,  1'b1, P_TERM_CTL, M_TERM_PD, M_TERM_PD, 1'b0);
                    default: step = mk(OP_POLL, 1'b0, '0, '0, '0, 1'b0);
                endcase
            end
        end else begin
            last = (pos == EXIT_LEN - 1);
            if (pos >= EXIT_PORT0) begin
                step = mk(OP_RMW, 1'b0, port_ofs(pos - EXIT_PORT0), M_PORT_EN, M_PORT_EN, 1'b0);
            end else begin
                unique case (pos)
                    0:  step = mk(OP_RMW,   1'b1, P_RX_CTL, M_RX_PD, '0, 1'b0);
                    1:  step = mk(OP_RMW,   1'b1, P_IO_CTL, M_IO_PD, '0, 1'b0);
                    2:  step = mk(OP_RMW,   1'b1, P_TERM_CTL, M_TERM_PD, '0, 1'b0);
                    3:  step = mk(OP_RMW,   1'b1, P_INIT, M_DLL_BYP, '0, 1'b0);
                    4:  step = mk(OP_WRITE, 1'b0, C_SW_CTL, '1, '0, 1'b0);
                    5:  step = mk(OP_RMW,   1'b0, C_MISC, M_INIT_EN, '0, 1'b0);
                    6:  step = mk(OP_WRITE, 1'b0, C_SW_CTL, '1, V_SW_DONE, 1'b0);
                    7:  step = mk(OP_POLL,  1'b0, C_SW_STAT, M_SW_ACK, M_SW_ACK, 1'b0);
                    8:  step = mk(OP_WRITE, 1'b1, P_INIT, '1, V_PHY_INIT, 1'b0);
                    9:  step = mk(OP_POLL,  1'b1, P_GSTAT, M_INIT_DONE, M_INIT_DONE, 1'b0);
                    10: step = mk(OP_WRITE, 1'b0, C_SW_CTL, '1, '0, 1'b0);
                    11: step = mk(OP_RMW,   1'b0, C_MISC, M_INIT_EN, M_INIT_EN, 1'b0);
                    12: step = mk(OP_WRITE, 1'b0, C_SW_CTL, '1, V_SW_DONE, 1'b0);
                    13: step = mk(OP_POLL,  1'b0, C_SW_STAT, M_SW_ACK, M_SW_ACK, 1'b0);
                    14: step = mk(OP_RMW,   1'b0, C_PWR_CTL, M_SR_REQ, '0, 1'b0);
                    15: step = mk(OP_POLL,  1'b0, C_STATUS, M_OPMODE, V_OP_NORMAL, 1'b0);
                    default: step = mk(OP_POLL, 1'b0, '0, '0, '0, 1'b0);
                endcase
            end
        end
    end
endmodule

// File: rtl/sr_seq_datapath.sv
module sr_seq_datapath
    import sr_seq_pkg::*;
(
    input  logic [SRS_DATA_W-1:0] rdata,
    input  logic [SRS_DATA_W-1:0] mask,
    input  logic [SRS_DATA_W-1:0] value,
    output logic [SRS_DATA_W-1:0] merged,
    output logic                  match
);
    always_comb begin
        merged = (rdata & ~mask) | (value & mask);
        match  = ((rdata & mask) == value);
    end
endmodule

// File: rtl/sr_seq.sv
module sr_seq
    import sr_seq_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int CNT_W     = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enter_req,
    input  logic                  exit_req,
    input  logic                  backup_mode,
    input  logic [CNT_W-1:0]      poll_limit,
    output logic                  bus_req,
    output logic                  bus_we,
    output logic                  bus_sel,
    output logic [SRS_ADDR_W-1:0] bus_addr,
    output logic [SRS_DATA_W-1:0] bus_wdata,
    input  logic                  bus_ack,
    input  logic [SRS_DATA_W-1:0] bus_rdata,
    output logic                  busy,
    output logic                  done,
    output logic                  in_self_refresh,
    output logic                  err
);
    localparam int EXIT_LEN = NUM_PORTS + 16;
    localparam int IDX_W    = $clog2(EXIT_LEN + 1);

    state_e                state, state_nx;
    logic [IDX_W-1:0]      idx;
    logic                  dir_exit;
    logic                  backup_q;
    logic [SRS_DATA_W-1:0] wdata_q;
    logic [CNT_W-1:0]      poll_cnt;
    logic                  done_q;
    logic                  in_sr_q;

    step_t                 step;
    logic                  step_last;
    logic [SRS_DATA_W-1:0] merged;
    logic                  match;

    logic start_enter, start_exit, noop_cmd, give_up;

    sr_seq_script #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_script (
        .exit_dir (dir_exit),
        .idx      (idx),
        .step     (step),
        .last     (step_last)
    );

    sr_seq_datapath u_dp (
        .rdata  (bus_rdata),
        .mask   (step.mask),
        .value  (step.value),
        .merged (merged),
        .match  (match)
    );

    always_comb begin
        start_enter = enter_req && !in_sr_q;
        start_exit  = !enter_req && exit_req && in_sr_q;
        noop_cmd    = (enter_req && in_sr_q) || (!enter_req && exit_req && !in_sr_q);
        give_up     = (poll_cnt >= poll_limit);
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start_enter || start_exit) state_nx = ST_ISSUE;
            ST_ISSUE: begin
                if (step.backup_skip && backup_q) state_nx = ST_ADVANCE;
                else if (step.op == OP_WRITE)     state_nx = ST_WRITE;
                else                              state_nx = ST_READ;
            end
            ST_READ: begin
                if (bus_ack) begin
                    if (step.op == OP_RMW) state_nx = ST_WRITE;
                    else if (match)        state_nx = ST_ADVANCE;
                    else if (give_up)      state_nx = ST_ERROR;
                end
            end
            ST_WRITE:   if (bus_ack) state_nx = ST_ADVANCE;
            ST_ADVANCE: state_nx = step_last ? ST_IDLE : ST_ISSUE;
            ST_ERROR:   state_nx = ST_ERROR;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx      <= '0;
            dir_exit <= 1'b0;
            backup_q <= 1'b0;
            wdata_q  <= '0;
            poll_cnt <= '0;
            done_q   <= 1'b0;
            in_sr_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start_enter || start_exit) begin
                        dir_exit <= start_exit;
                        idx      <= '0;
                        backup_q <= backup_mode;
                    end else if (noop_cmd) begin
                        done_q <= 1'b1;
                    end
                end
                ST_ISSUE: begin
                    wdata_q  <= step.value;
                    poll_cnt <= CNT_W'(1);
                end
                ST_READ: begin
                    if (bus_ack) begin
                        if (step.op == OP_RMW) wdata_q <= merged;
                        else if (!match)       poll_cnt <= poll_cnt + CNT_W'(1);
                    end
                end
                ST_ADVANCE: begin
                    if (step_last) begin
                        done_q  <= 1'b1;
                        in_sr_q <= !dir_exit;
                    end else begin
                        idx <= idx + IDX_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_req         = (state == ST_READ) || (state == ST_WRITE);
        bus_we          = (state == ST_WRITE);
        bus_sel         = step.sel;
        bus_addr        = step.addr;
        bus_wdata       = wdata_q;
        busy            = (state != ST_IDLE) && (state != ST_ERROR);
        err             = (state == ST_ERROR);
        done            = done_q;
        in_self_refresh = in_sr_q;
    end
endmodule

// File: rtl/sr_seq_chk.sv
module sr_seq_chk
    import sr_seq_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_req,
    input logic                  bus_ack,
    input logic                  bus_we,
    input logic                  bus_sel,
    input logic [SRS_ADDR_W-1:0] bus_addr,
    input logic [SRS_DATA_W-1:0] bus_wdata,
    input logic                  busy,
    input logic                  done,
    input logic                  in_self_refresh,
    input logic                  err
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_sel)
                                && $stable(bus_addr) && $stable(bus_wdata)); // R11
    AST_NO_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req); // R10
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !err); // R4
    AST_SR_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_self_refresh != $past(in_self_refresh)) |-> done); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err && !done && !bus_req); // R9
endmodule

bind sr_seq sr_seq_chk u_chk (.*);

// File: tb/sr_seq_test.sv
module sr_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enter_req = 1'b0, exit_req = 1'b0, backup_mode = 1'b0;
    logic [15:0] poll_limit = 16'd100;
    logic        bus_req, bus_we, bus_sel, bus_ack;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata, rd_val;
    logic        busy, done, in_sr, err;

    int n_chk = 0, n_fail = 0;
    int pstat_busy_until = 0;

    always #2 clk = ~clk;

    sr_seq uut (
        .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .exit_req(exit_req),
        .backup_mode(backup_mode), .poll_limit(poll_limit),
        .bus_req(bus_req), .bus_we(bus_we), .bus_sel(bus_sel), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .busy(busy), .done(done), .in_self_refresh(in_sr), .err(err)
    );

    // register model of both targets
    logic [31:0] cm [64];
    logic [31:0] pm [64];
    logic [40:0] log_w [256];
    int          log_n;
    int          pstat_reads;

    always_comb begin
        if (!bus_sel) begin
            case (bus_addr)
                8'h3C:   rd_val = (pstat_reads < pstat_busy_until) ? 32'h1F : 32'h0;
                8'h04:   rd_val = cm[12][5] ? 32'h23 : 32'h01;
                8'h24:   rd_val = {31'b0, cm[8][0]};
                default: rd_val = cm[bus_addr[7:2]];
            endcase
        end else begin
            case (bus_addr)
                8'h0C:   rd_val = {31'b0, pm[1][0]};
                default: rd_val = pm[bus_addr[7:2]];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) begin
                cm[i] <= 32'h0;
                pm[i] <= 32'h0;
            end
            for (int i = 16; i < 21; i++) cm[i] <= 32'h1;
            cm[10]      <= 32'h1;
            bus_ack     <= 1'b0;
            bus_rdata   <= 32'h0;
            log_n       <= 0;
            pstat_reads <= 0;
        end else if (bus_req && !bus_ack) begin
            bus_ack <= 1'b1;
            if (bus_we) begin
                if (bus_sel) pm[bus_addr[7:2]] <= bus_wdata;
                else         cm[bus_addr[7:2]] <= bus_wdata;
                log_w[log_n[7:0]] <= {bus_sel, bus_addr, bus_wdata};
                log_n <= log_n + 1;
            end else begin
                bus_rdata <= rd_val;
                if (!bus_sel && bus_addr == 8'h3C) pstat_reads <= pstat_reads + 1;
            end
        end else begin
            bus_ack <= 1'b0;
        end
    end

    // expected write trace {sel, addr, data}: entry (10) then exit (17)
    localparam logic [40:0] EXP [27] = '{
        41'h040_0000_0000, 41'h044_0000_0000, 41'h048_0000_0000, 41'h04C_0000_0000,
        41'h050_0000_0000, 41'h030_0000_0020, 41'h104_0002_0000, 41'h128_0000_0008,
        41'h124_0005_0008, 41'h12C_0001_0000,
        41'h128_0000_0000, 41'h124_0000_0000, 41'h12C_0000_0000, 41'h104_0000_0000,
        41'h020_0000_0000, 41'h028_0000_0000, 41'h020_0000_0001, 41'h104_0000_0017,
        41'h020_0000_0000, 41'h028_0000_0001, 41'h020_0000_0001, 41'h030_0000_0000,
        41'h040_0000_0001, 41'h044_0000_0001, 41'h048_0000_0001, 41'h04C_0000_0001,
        41'h050_0000_0001
    };

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic pulse(input bit ent);
        @(negedge clk);
        if (ent) enter_req = 1'b1; else exit_req = 1'b1;
        @(negedge clk);
        enter_req = 1'b0;
        exit_req  = 1'b0;
    endtask

    task automatic wait_done(string tag);
        int k = 0;
        while (!done && k < 3000) begin
            @(negedge clk);
            k++;
        end
        chk({tag, " done seen"}, 64'(done), 64'd1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int base, rd0;
        do_reset();
        // R12 reset state
        chk("R12 busy", 64'(busy), 0);
        chk("R12 done", 64'(done), 0);
        chk("R12 err", 64'(err), 0);
        chk("R12 in_sr", 64'(in_sr), 0);
        chk("R12 bus_req", 64'(bus_req), 0);

        // R1..R4 entry, port status busy for 3 reads (R9 repeat)
        pstat_busy_until = pstat_reads + 3;
        rd0 = pstat_reads;
        base = log_n;
        backup_mode = 1'b0;
        pulse(1);
        wait_done("R4 entry");
        chk("R4 entry write count", 64'(log_n - base), 64'd10);
        for (int i = 0; i < 10; i++)
            chk($sformatf("R1/R2/R3/R4 entry write %0d", i), 64'(log_w[base + i]), 64'(EXP[i]));
        chk("R9 poll repeats until match", 64'(pstat_reads - rd0), 64'd4);
        @(negedge clk);
        chk("R4 in_sr after entry", 64'(in_sr), 1);

        // R10 enter while already in self-refresh: done next cycle, no access
        base = log_n;
        pulse(1);
        chk("R10 noop enter done", 64'(done), 1);
        repeat (3) @(negedge clk);
        chk("R10 noop enter no bus", 64'(log_n - base), 0);
        chk("R10 noop enter in_sr", 64'(in_sr), 1);

        // R5..R8 exit, enter pulse during busy must be ignored (R10)
        base = log_n;
        pulse(0);
        repeat (6) @(negedge clk);
        chk("R10 busy during exit", 64'(busy), 1);
        pulse(1);
        wait_done("R8 exit");
        chk("R8 exit write count", 64'(log_n - base), 64'd17);
        for (int i = 0; i < 17; i++)
            chk($sformatf("R5/R6/R7/R8 exit write %0d", i), 64'(log_w[base + i]), 64'(EXP[10 + i]));
        @(negedge clk);
        chk("R8 in_sr after exit", 64'(in_sr), 0);
        repeat (5) @(negedge clk);
        chk("R10 ignored enter left idle", 64'(busy), 0);

        // R10 exit while not in self-refresh
        base = log_n;
        pulse(0);
        chk("R10 noop exit done", 64'(done), 1);
        repeat (3) @(negedge clk);
        chk("R10 noop exit no bus", 64'(log_n - base), 0);

        // R3 backup mode entry skips DLL bypass
        do_reset();
        base = log_n;
        backup_mode = 1'b1;
        pulse(1);
        backup_mode = 1'b0;
        wait_done("R3 backup entry");
        chk("R3 backup write count", 64'(log_n - base), 64'd9);
        for (int i = 0; i < 9; i++)
            chk($sformatf("R3 backup write %0d", i), 64'(log_w[base + i]),
                64'(EXP[(i < 6) ? i : i + 1]));

        // R9 timeout
        do_reset();
        poll_limit = 16'd5;
        pstat_busy_until = pstat_reads + 1000;
        rd0 = pstat_reads;
        pulse(1);
        for (int k = 0; k < 500 && !err; k++) @(negedge clk);
        chk("R9 err raised", 64'(err), 1);
        chk("R9 busy low in error", 64'(busy), 0);
        chk("R9 reads before error", 64'(pstat_reads - rd0), 64'd5);
        base = log_n;
        pulse(0);
        repeat (4) @(negedge clk);
        chk("R9 error ignores commands", 64'({err, busy, bus_req, done}), 64'b1000);
        chk("R9 error no bus", 64'(log_n - base), 0);
        do_reset();
        chk("R9 reset clears err", 64'(err), 0);
        poll_limit = 16'd100;

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule